// File: doc/BRIEF.md
# Send-Command Read Request Generator

This block sits on the receive and transmit sides of a packet-based host link that moves 64-bit beats. It watches posted memory writes that land in the device's first base address window. The offset written to carries a small command word: an opcode, a buffer number and a length. When the opcode asks for a send, the 64-bit data of that write is taken as the host address of a buffer. The block then issues a two-beat memory-read request, so that the device fetches that buffer as bus master. The buffer number becomes the request tag, so the completion can later be matched to its buffer.

The request passes through a one-entry command stage and a one-entry request slot, then a transmit sequencer that holds each beat until the link accepts it. Opcodes other than send, writes outside the window and packets that are not three-dword memory writes leave the transmit side idle. The interrupt output stays low. The size-limit inputs and the interrupt acknowledge are accepted and not used.

Top module: `cmdrq_gen`

## Requirements
- R1: After reset, while idle and while a write is being received, tx_beat is all zeros and tx_sof, tx_eof, tx_half and tx_valid are low.
- R2: For a send command, the first request beat appears after the second rising edge that follows the edge sampling the eof beat of the write. On the two cycles before it, the transmit outputs are idle.
- R3: The first request beat has tx_sof=1 and tx_eof=0, and contains: bit 63=0, format bits 62:61=00, type bits 60:56=0, bits 55:42=0, requester ID from req_id in bits 31:16, tag in bits 15:8 equal to the 4-bit buffer number zero-extended, and 0xFF in bits 7:0.
- R4: The 10-bit dword length in bits 41:32 of the first request beat is twice the 9-bit length field of the command.
- R5: The second request beat carries write-data bits 31:3 followed by three zero bits in its bits 63:32, and zero in bits 31:0, with tx_eof=1, tx_half=1 and tx_sof=0.
- R6: A beat with tx_valid=1 stays unchanged on every output while tx_ready is low.
- R7: On the cycle after the last request beat is accepted, the transmit outputs are idle.
- R8: A receive beat counts only when rx_valid and rx_bar_hit are both high. A write with rx_valid low or rx_bar_hit low produces no request. Idle beats with rx_valid low may be placed between the beats of a write.
- R9: A packet whose sof beat does not have format 10 and type 00000 in bits 62:56 produces no request.
- R10: The command sits at bits 4:3 of the 32-bit window address, which is the upper half of the second write beat. Values 00, 10 and 11 produce no request. Only 01 (send) does. The buffer number sits at bits 8:5 and the length at bits 18:10.
- R11: A send that completes while an earlier request is still being transmitted is emitted after that request has fully left, in arrival order, with its own fields.
- R12: The interrupt output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_beat | input | 64 | Receive beat |
| rx_sof | input | 1 | First beat of a receive packet |
| rx_eof | input | 1 | Last beat of a receive packet |
| rx_valid | input | 1 | Receive beat is valid |
| rx_bar_hit | input | 1 | Packet targets the first address window |
| tx_beat | output | 64 | Transmit beat, zero when idle |
| tx_sof | output | 1 | First beat of a request |
| tx_eof | output | 1 | Last beat of a request |
| tx_half | output | 1 | Only bits 63:32 of the beat are meaningful |
| tx_valid | output | 1 | Transmit beat is valid |
| tx_ready | input | 1 | Link accepts the current transmit beat |
| irq | output | 1 | Interrupt request, held low |
| irq_ack | input | 1 | Interrupt acknowledge, unused |
| req_id | input | 16 | Local requester ID |
| max_rd_size | input | 3 | Maximum read request size, unused |
| max_wr_size | input | 3 | Maximum payload size, unused |

## Verification
The assertions assume that every write packet opens with an sof beat and that tx_ready is a plain level, sampled only while tx_valid is high. They also assume that no more than two send commands pile up behind a stalled link, because a third would be dropped in the command stage. The directed stimulus sends whole packets with one sof and one eof each. It changes tx_ready only between edges and never queues more than two sends while the link is held off.

// File: rtl/cmdrq_pkg.sv
package cmdrq_pkg;

  localparam int BEAT_W     = 64;
  localparam int HALF_W     = BEAT_W / 2;
  localparam int ID_W       = 16;
  localparam int BUFN_W     = 4;
  localparam int LEN_W      = 9;
  localparam int TAG_W      = 8;
  localparam int DWLEN_W    = LEN_W + 1;
  localparam int ADDR_ALIGN = 3;

  // header field positions shared by receive and transmit packets
  localparam int FMT_LSB    = 61;
  localparam int FMT_MSB    = 62;
  localparam int TYPE_LSB   = 56;
  localparam int TYPE_MSB   = 60;
  localparam int DWLEN_LSB  = 32;
  localparam int RID_LSB    = 16;
  localparam int TAG_LSB    = 8;
  localparam int BE_LSB     = 0;

  localparam logic [1:0] FMT_WR3 = 2'b10;
  localparam logic [1:0] FMT_RD3 = 2'b00;
  localparam logic [7:0] BE_ALL  = 8'hFF;

  // command word positions inside the window address
  localparam int OP_LSB     = 3;
  localparam int BUFN_LSB   = 5;
  localparam int LEN_LSB    = 10;

  typedef enum logic [1:0] {
    OP_STAT = 2'b00,
    OP_SEND = 2'b01,
    OP_RECV = 2'b10,
    OP_MGMT = 2'b11
  } op_e;

  typedef struct packed {
    logic [BUFN_W-1:0] bufn;
    logic [LEN_W-1:0]  len;
    logic [HALF_W-1:0] addr;
  } sendcmd_t;

endpackage

// File: rtl/cmdrq_rst_sync.sv
module cmdrq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/cmdrq_rx_parse.sv
module cmdrq_rx_parse
  import cmdrq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BEAT_W-1:0] rx_beat_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic              rx_valid_i,
  input  logic              rx_hit_i,
  input  logic              cmd_take_i,
  output logic              cmd_vld_o,
  output sendcmd_t          cmd_o
);
  typedef enum logic [1:0] {PS_IDLE, PS_ADDR, PS_DATA} pst_e;

  pst_e              st_q, st_n;
  op_e               op_q, op_n;
  logic [BUFN_W-1:0] bufn_q, bufn_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic              vld_q, vld_n;
  sendcmd_t          cmd_q, cmd_n;

  logic              beat_ok;
  logic              hdr_ok;
  logic              fire;
  logic [HALF_W-1:0] hi_word;
  logic              parse_unused;

  assign hi_word = rx_beat_i[BEAT_W-1:HALF_W];
  assign beat_ok = rx_valid_i & rx_hit_i;
  assign hdr_ok  = (rx_beat_i[FMT_MSB:FMT_LSB] == FMT_WR3) &&
                   (rx_beat_i[TYPE_MSB:TYPE_LSB] == '0);
  assign parse_unused = ^{rx_beat_i[HALF_W-1:0], hi_word[ADDR_ALIGN-1:0]};

  always_comb begin
    st_n   = st_q;
    op_n   = op_q;
    bufn_n = bufn_q;
    len_n  = len_q;
    fire   = 1'b0;
    if (beat_ok) begin
      if (rx_sof_i) begin
        st_n = (hdr_ok && !rx_eof_i) ? PS_ADDR : PS_IDLE;
      end else begin
        case (st_q)
          PS_ADDR: begin
            if (rx_eof_i) begin
              st_n = PS_IDLE;
            end else begin
              st_n   = PS_DATA;
              op_n   = op_e'(hi_word[OP_LSB+1:OP_LSB]);
              bufn_n = hi_word[BUFN_LSB +: BUFN_W];
              len_n  = hi_word[LEN_LSB +: LEN_W];
            end
          end
          PS_DATA: begin
            st_n = PS_IDLE;
            fire = rx_eof_i && (op_q == OP_SEND);
          end
          default: st_n = PS_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    vld_n = vld_q & ~cmd_take_i;
    cmd_n = cmd_q;
    if (fire && !vld_n) begin
      vld_n      = 1'b1;
      cmd_n.bufn = bufn_q;
      cmd_n.len  = len_q;
      cmd_n.addr = {hi_word[HALF_W-1:ADDR_ALIGN], {ADDR_ALIGN{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      op_q   <= OP_STAT;
      bufn_q <= '0;
      len_q  <= '0;
      vld_q  <= 1'b0;
      cmd_q  <= '0;
    end else begin
      st_q   <= st_n;
      op_q   <= op_n;
      bufn_q <= bufn_n;
      len_q  <= len_n;
      vld_q  <= vld_n;
      cmd_q  <= cmd_n;
    end
  end

  assign cmd_vld_o = vld_q;
  assign cmd_o     = cmd_q;

  // R8
  issue_on_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(rx_valid_i && rx_hit_i && rx_eof_i && !rx_sof_i));

endmodule

// File: rtl/cmdrq_req_slot.sv
module cmdrq_req_slot
  import cmdrq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_vld_i,
  input  sendcmd_t cmd_i,
  output logic     cmd_take_o,
  input  logic     take_i,
  output logic     req_vld_o,
  output sendcmd_t req_o
);
  logic     full_q, full_n;
  sendcmd_t slot_q, slot_n;

  assign cmd_take_o = cmd_vld_i & ~full_q;

  always_comb begin
    full_n = full_q;
    slot_n = slot_q;
    if (take_i) full_n = 1'b0;
    if (cmd_take_o) begin
      full_n = 1'b1;
      slot_n = cmd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      slot_q <= '0;
    end else begin
      full_q <= full_n;
      slot_q <= slot_n;
    end
  end

  assign req_vld_o = full_q;
  assign req_o     = slot_q;

  // R11
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !take_i |=> full_q && $stable(slot_q));

endmodule

// File: rtl/cmdrq_tx_seq.sv
module cmdrq_tx_seq
  import cmdrq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld_i,
  input  sendcmd_t          req_i,
  input  logic [ID_W-1:0]   req_id_i,
  output logic              take_o,
  output logic [BEAT_W-1:0] tx_beat_o,
  output logic              tx_sof_o,
  output logic              tx_eof_o,
  output logic              tx_half_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);
  typedef enum logic [1:0] {TS_IDLE, TS_HDR, TS_ADDR} tst_e;

  tst_e              st_q, st_n;
  logic [BEAT_W-1:0] beat_q, beat_n;
  logic              sof_q, sof_n;
  logic              eof_q, eof_n;
  logic              half_q, half_n;
  logic              vld_q, vld_n;
  logic [HALF_W-1:0] addr_q, addr_n;
  logic [BEAT_W-1:0] hdr;

  always_comb begin
    hdr = '0;
    hdr[FMT_MSB:FMT_LSB]              = FMT_RD3;
    hdr[DWLEN_LSB +: DWLEN_W]         = {req_i.len, 1'b0};
    hdr[RID_LSB +: ID_W]              = req_id_i;
    hdr[TAG_LSB +: TAG_W]             = {{(TAG_W-BUFN_W){1'b0}}, req_i.bufn};
    hdr[BE_LSB +: 8]                  = BE_ALL;
  end

  assign take_o = (st_q == TS_IDLE) && req_vld_i;

  always_comb begin
    st_n   = st_q;
    beat_n = beat_q;
    sof_n  = sof_q;
    eof_n  = eof_q;
    half_n = half_q;
    vld_n  = vld_q;
    addr_n = addr_q;
    case (st_q)
      TS_IDLE: begin
        if (req_vld_i) begin
          st_n   = TS_HDR;
          beat_n = hdr;
          sof_n  = 1'b1;
          eof_n  = 1'b0;
          half_n = 1'b0;
          vld_n  = 1'b1;
          addr_n = req_i.addr;
        end else begin
          beat_n = '0;
          sof_n  = 1'b0;
          eof_n  = 1'b0;
          half_n = 1'b0;
          vld_n  = 1'b0;
        end
      end
      TS_HDR: begin
        if (tx_ready_i) begin
          st_n   = TS_ADDR;
          beat_n = {addr_q, {HALF_W{1'b0}}};
          sof_n  = 1'b0;
          eof_n  = 1'b1;
          half_n = 1'b1;
        end
      end
      TS_ADDR: begin
        if (tx_ready_i) begin
          st_n   = TS_IDLE;
          beat_n = '0;
          eof_n  = 1'b0;
          half_n = 1'b0;
          vld_n  = 1'b0;
        end
      end
      default: st_n = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TS_IDLE;
      beat_q <= '0;
      sof_q  <= 1'b0;
      eof_q  <= 1'b0;
      half_q <= 1'b0;
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      st_q   <= st_n;
      beat_q <= beat_n;
      sof_q  <= sof_n;
      eof_q  <= eof_n;
      half_q <= half_n;
      vld_q  <= vld_n;
      addr_q <= addr_n;
    end
  end

  assign tx_beat_o  = beat_q;
  assign tx_sof_o   = sof_q;
  assign tx_eof_o   = eof_q;
  assign tx_half_o  = half_q;
  assign tx_valid_o = vld_q;

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> (beat_q == '0) && !sof_q && !eof_q && !half_q);

  // R3
  sof_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (sof_q != eof_q));

  // R5
  half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_q |-> eof_q && vld_q);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && !tx_ready_i |=> vld_q && $stable(beat_q) && $stable(sof_q) &&
                             $stable(eof_q) && $stable(half_q));

  // R7
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && eof_q && tx_ready_i |=> !vld_q);

endmodule

// File: rtl/cmdrq_gen.sv
module cmdrq_gen
  import cmdrq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BEAT_W-1:0] rx_beat,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_valid,
  input  logic              rx_bar_hit,
  output logic [BEAT_W-1:0] tx_beat,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              tx_half,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              irq,
  input  logic              irq_ack,
  input  logic [ID_W-1:0]   req_id,
  input  logic [2:0]        max_rd_size,
  input  logic [2:0]        max_wr_size
);
  logic     rst_sync_n;
  logic     cmd_vld;
  sendcmd_t cmd;
  logic     cmd_take;
  logic     req_vld;
  sendcmd_t req;
  logic     req_take;
  logic     top_unused;

  assign top_unused = ^{irq_ack, max_rd_size, max_wr_size};
  assign irq        = 1'b0;

  cmdrq_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  cmdrq_rx_parse parse_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rx_beat_i  (rx_beat),
    .rx_sof_i   (rx_sof),
    .rx_eof_i   (rx_eof),
    .rx_valid_i (rx_valid),
    .rx_hit_i   (rx_bar_hit),
    .cmd_take_i (cmd_take),
    .cmd_vld_o  (cmd_vld),
    .cmd_o      (cmd)
  );

  cmdrq_req_slot slot_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd_vld_i  (cmd_vld),
    .cmd_i      (cmd),
    .cmd_take_o (cmd_take),
    .take_i     (req_take),
    .req_vld_o  (req_vld),
    .req_o      (req)
  );

  cmdrq_tx_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_vld_i  (req_vld),
    .req_i      (req),
    .req_id_i   (req_id),
    .take_o     (req_take),
    .tx_beat_o  (tx_beat),
    .tx_sof_o   (tx_sof),
    .tx_eof_o   (tx_eof),
    .tx_half_o  (tx_half),
    .tx_valid_o (tx_valid),
    .tx_ready_i (tx_ready)
  );

endmodule

// File: tb/cmdrq_gen_tb_top.sv
module cmdrq_gen_tb_top;
  localparam logic [15:0] MY_ID  = 16'hA5C3;
  localparam logic [15:0] HOST_ID = 16'h1234;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] rx_beat;
  logic        rx_sof, rx_eof, rx_valid, rx_bar_hit;
  logic [63:0] tx_beat;
  logic        tx_sof, tx_eof, tx_half, tx_valid, tx_ready;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  cmdrq_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .rx_beat(rx_beat), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_valid(rx_valid), .rx_bar_hit(rx_bar_hit),
    .tx_beat(tx_beat), .tx_sof(tx_sof), .tx_eof(tx_eof),
    .tx_half(tx_half), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .irq(irq), .irq_ack(1'b0), .req_id(MY_ID),
    .max_rd_size(3'd2), .max_wr_size(3'd1)
  );

  function automatic logic [63:0] exp_hdr(logic [8:0] len, logic [3:0] bufn);
    return {1'b0, 2'b00, 5'b0, 8'h00, 6'b0, len, 1'b0, MY_ID,
            3'b000, 1'b0, bufn, 8'hFF};
  endfunction

  function automatic logic [63:0] exp_adr(logic [63:0] a);
    return {a[31:3], 3'b000, 32'h0};
  endfunction

  task automatic chk(string req, logic [63:0] eb, logic es, logic ee,
                     logic eh, logic ev);
    n_tests++;
    if ({tx_beat, tx_sof, tx_eof, tx_half, tx_valid, irq} !==
        {eb, es, ee, eh, ev, 1'b0}) begin
      n_fail++;
      $display("FAIL %s: got beat=%h sof=%b eof=%b half=%b vld=%b irq=%b exp beat=%h sof=%b eof=%b half=%b vld=%b irq=0 (R12)",
               req, tx_beat, tx_sof, tx_eof, tx_half, tx_valid, irq,
               eb, es, ee, eh, ev);
    end
  endtask

  task automatic chk_idle(string req);
    chk(req, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic drive(logic [63:0] b, logic s, logic e, logic v, logic h);
    rx_beat = b; rx_sof = s; rx_eof = e; rx_valid = v; rx_bar_hit = h;
    @(negedge clk);
  endtask

  // builds a 3-beat write; returns at the falling edge after the eof edge
  task automatic wr_pkt(logic [1:0] cmd, logic [3:0] bufn, logic [8:0] len,
                        logic [63:0] addr, logic [1:0] fmt, logic v,
                        logic h, bit gap, bit quiet);
    logic [31:0] win;
    win = {13'b0, len, 1'b0, bufn, cmd, 3'b000};
    drive({1'b0, fmt, 5'b0, 8'h00, 16'h0002, HOST_ID, 8'h00, 8'h0F},
          1'b1, 1'b0, v, h);
    if (quiet) chk_idle("R1 during header");
    drive({win, addr[63:32]}, 1'b0, 1'b0, v, h);
    if (quiet) chk_idle("R1 during address");
    if (gap) drive(64'hDEAD_BEEF_0BAD_F00D, 1'b0, 1'b1, 1'b0, 1'b1);
    drive({addr[31:0], 32'h0}, 1'b0, 1'b1, v, h);
    rx_beat = '0; rx_sof = 0; rx_eof = 0; rx_valid = 0; rx_bar_hit = 0;
    if (quiet) chk_idle("R1 after eof");
  endtask

  task automatic t_reset();
    rst_n = 0; tx_ready = 0;
    rx_beat = '0; rx_sof = 0; rx_eof = 0; rx_valid = 0; rx_bar_hit = 0;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_idle("R1 after reset");
  endtask

  task automatic t_basic();
    logic [63:0] a = 64'h0000_0000_0000_0010;
    tx_ready = 0;
    wr_pkt(2'b01, 4'd2, 9'd2, a, 2'b10, 1, 1, 0, 1);
    @(negedge clk); chk_idle("R2 second idle cycle");
    @(negedge clk); chk("R2 R3 R4 first beat", exp_hdr(9'd2, 4'd2), 1, 0, 0, 1);
    @(negedge clk); chk("R6 held", exp_hdr(9'd2, 4'd2), 1, 0, 0, 1);
    tx_ready = 1;
    @(negedge clk); chk("R5 second beat", exp_adr(a), 0, 1, 1, 1);
    @(negedge clk); chk_idle("R7 after last beat");
    tx_ready = 0;
  endtask

  task automatic t_limits(bit gap);
    logic [63:0] a = 64'hFFFF_0123_FFFF_FFF8;
    tx_ready = 1;
    wr_pkt(2'b01, 4'd15, 9'h1FF, a, 2'b10, 1, 1, gap, 1);
    @(negedge clk); chk_idle("R2 idle before request");
    @(negedge clk); chk(gap ? "R8 gap first beat" : "R4 max length",
                        exp_hdr(9'h1FF, 4'd15), 1, 0, 0, 1);
    @(negedge clk); chk("R5 high address", exp_adr(a), 0, 1, 1, 1);
    @(negedge clk); chk_idle("R7 gap");
    tx_ready = 0;
  endtask

  task automatic t_ignore();
    logic [63:0] a = 64'h40;
    tx_ready = 1;
    wr_pkt(2'b01, 4'd1, 9'd1, a, 2'b10, 0, 1, 0, 0);
    repeat (3) begin @(negedge clk); chk_idle("R8 valid low"); end
    wr_pkt(2'b01, 4'd1, 9'd1, a, 2'b10, 1, 0, 0, 0);
    repeat (3) begin @(negedge clk); chk_idle("R8 window miss"); end
    wr_pkt(2'b01, 4'd1, 9'd1, a, 2'b00, 1, 1, 0, 0);
    repeat (3) begin @(negedge clk); chk_idle("R9 not a write"); end
    tx_ready = 0;
  endtask

  task automatic t_other_cmds();
    tx_ready = 1;
    for (int c = 0; c < 4; c++) begin
      if (c == 1) continue;
      wr_pkt(2'(c), 4'd3, 9'd4, 64'h80, 2'b10, 1, 1, 0, 1);
      repeat (3) begin @(negedge clk); chk_idle("R10 non-send opcode"); end
    end
    tx_ready = 0;
  endtask

  task automatic t_queue();
    logic [63:0] a = 64'h1000;
    logic [63:0] b = 64'h2008;
    tx_ready = 0;
    wr_pkt(2'b01, 4'd1, 9'd3, a, 2'b10, 1, 1, 0, 0);
    wr_pkt(2'b01, 4'd3, 9'd5, b, 2'b10, 1, 1, 0, 0);
    chk("R6 first request held", exp_hdr(9'd3, 4'd1), 1, 0, 0, 1);
    tx_ready = 1;
    @(negedge clk); chk("R5 first request beat 2", exp_adr(a), 0, 1, 1, 1);
    @(negedge clk); chk_idle("R7 between requests");
    @(negedge clk); chk("R11 queued header", exp_hdr(9'd5, 4'd3), 1, 0, 0, 1);
    @(negedge clk); chk("R11 queued address", exp_adr(b), 0, 1, 1, 1);
    @(negedge clk); chk_idle("R7 after queued");
    tx_ready = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_limits(0);
    t_limits(1);
    t_ignore();
    t_other_cmds();
    t_queue();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule